// File: doc/BRIEF.md
# Channel-Parallel 3x3 Convolution MAC Array

This block computes one 3x3 convolution window for eight input channels and eight output channels at the same time. It uses a square grid of multiply-accumulate elements. Row r of the grid serves input channel r and column c serves output channel c. The caller feeds the window one pixel per accepted step:

- eight signed activations, one per input channel, each broadcast along its row;
- sixty-four signed weights, one per input/output channel pair.

Each column multiplies its row activations by its own weights and reduces the eight products in an adder tree. The result is added into that output channel's running partial sum.

A start pulse captures eight signed 32-bit bias values. It also rewinds the pixel counter. The first accepted pixel of a window adds its column sums to the stored bias, and later pixels add to the running sums. Pixels are taken in row-major order, from (0,0) to (2,2). After the ninth accepted pixel the block presents the eight finished window sums and raises a one-cycle done pulse. The counter then wraps, so the next window can follow at once with the same bias. The caller may drop the valid input between pixels at any time.

Top module: `chan_conv_array`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and result_o is all zeros until a window completes.
- R2: done_o rises for exactly one clock cycle, in the cycle after the ninth accepted step of a window (a step is accepted on a rising edge where valid_i is 1 and start_i is 0).
- R3: On done_o, field c of result_o (bits 32c+31..32c) equals bias c plus the sum, over the 9 accepted steps and r = 0..7, of act_i field r (bits 8r+7..8r) times wgt_i field 8r+c (bits 8(8r+c)+7..8(8r+c)), all signed.
- R4: A cycle with valid_i low has no effect: act_i and wgt_i are ignored, and the partial sums and step count hold.
- R5: start_i restarts the window: steps accepted before it are discarded, and valid_i in the same cycle as start_i is ignored.
- R6: start_i captures bias_i (field c, bits 32c+31..32c, for output channel c). Windows that follow without a new start reuse that bias.
- R7: Accumulation is 32-bit two's complement that wraps without saturation.
- R8: result_o holds its value in every cycle in which done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture bias and begin a new window |
| bias_i | input | 256 | Eight signed 32-bit bias values, channel c at bits 32c+31..32c |
| valid_i | input | 1 | Current pixel's activations and weights are present |
| act_i | input | 64 | Eight signed 8-bit activations, input channel r at bits 8r+7..8r |
| wgt_i | input | 512 | Sixty-four signed 8-bit weights, pair (r,c) at index 8r+c |
| done_o | output | 1 | One-cycle pulse when a window is finished |
| result_o | output | 256 | Eight signed 32-bit window sums, output channel c at bits 32c+31..32c |

## Verification
The bench builds the array with its default parameters: eight rows, eight columns, 8-bit operands, 32-bit sums and a 3x3 window. This makes the full 72-product reduction per column observable, including cases where every product takes its extreme value. A bias near the positive limit of a 32-bit value brings the wrap-around case within reach. Restart in the middle of a window, idle gaps carrying junk data, and back-to-back windows after the step counter wraps are all driven through these same default dimensions.

// File: rtl/conv_array_pkg.sv
package conv_array_pkg;

  // Operation the step controller asks of the accumulator bank
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_SEED = 2'd1,
    ACC_ADD  = 2'd2
  } acc_op_e;

  localparam int unsigned DEF_ROWS = 8;
  localparam int unsigned DEF_COLS = 8;
  localparam int unsigned DEF_DW   = 8;
  localparam int unsigned DEF_ACCW = 32;
  localparam int unsigned DEF_KH   = 3;
  localparam int unsigned DEF_KW   = 3;

endpackage

// File: rtl/cw_col_tree.sv
module cw_col_tree #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned SW   = 32
) (
  input  logic [ROWS*DW-1:0] act_i,
  input  logic [ROWS*DW-1:0] wgt_i,
  output logic [SW-1:0]      sum_o
);
  localparam int unsigned PW     = 2 * DW;
  localparam int unsigned LEVELS = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned LEAVES = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [SW-1:0] node [NODES];

  // Leaf products, sign-extended to the sum width; unused leaves are zero
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < ROWS) begin : g_prod
      logic signed [DW-1:0] a_s;
      logic signed [DW-1:0] w_s;
      logic signed [PW-1:0] p_s;
      always_comb begin
        a_s = act_i[i*DW +: DW];
        w_s = wgt_i[i*DW +: DW];
        p_s = a_s * w_s;
        node[LEAVES-1+i] = {{(SW-PW){p_s[PW-1]}}, p_s};
      end
    end else begin : g_pad
      always_comb node[LEAVES-1+i] = '0;
    end
  end

  // Internal adder nodes
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_add
    always_comb node[n] = node[2*n+1] + node[2*n+2];
  end

  assign sum_o = node[0];

endmodule

// File: rtl/cw_step_ctrl.sv
module cw_step_ctrl
  import conv_array_pkg::*;
#(
  parameter int unsigned STEPS = 9,
  localparam int unsigned STW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           valid_i,
  output acc_op_e        op_o,
  output logic           last_o,
  output logic           done_o,
  output logic [STW-1:0] step_o
);
  localparam logic [STW-1:0] LAST_STEP = STW'(STEPS - 1);

  logic [STW-1:0] step_q, step_d;
  logic           done_q, done_d;
  logic           step_en;

  // Next-state logic
  always_comb begin
    op_o    = ACC_HOLD;
    last_o  = 1'b0;
    step_d  = step_q;
    step_en = 1'b0;
    if (start_i) begin
      step_d  = '0;
      step_en = 1'b1;
    end else if (valid_i) begin
      step_en = 1'b1;
      op_o    = (step_q == '0) ? ACC_SEED : ACC_ADD;
      if (step_q == LAST_STEP) begin
        step_d = '0;
        last_o = 1'b1;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
    done_d = last_o;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign step_o = step_q;

endmodule

// File: rtl/cw_acc_bank.sv
module cw_acc_bank
  import conv_array_pkg::*;
#(
  parameter int unsigned COLS = 8,
  parameter int unsigned ACCW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_bias_i,
  input  logic [COLS*ACCW-1:0] bias_i,
  input  acc_op_e              op_i,
  input  logic                 last_i,
  input  logic [COLS*ACCW-1:0] col_sum_i,
  output logic [COLS*ACCW-1:0] result_o
);

  logic [COLS*ACCW-1:0] bias_q;
  logic [COLS*ACCW-1:0] acc_q, acc_d;
  logic [COLS*ACCW-1:0] res_q;
  logic                 acc_en;

  // Per-column next partial sum
  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_comb begin
      unique case (op_i)
        ACC_SEED: acc_d[c*ACCW +: ACCW] = bias_q[c*ACCW +: ACCW] + col_sum_i[c*ACCW +: ACCW];
        ACC_ADD:  acc_d[c*ACCW +: ACCW] = acc_q[c*ACCW +: ACCW]  + col_sum_i[c*ACCW +: ACCW];
        default:  acc_d[c*ACCW +: ACCW] = acc_q[c*ACCW +: ACCW];
      endcase
    end
  end

  assign acc_en = (op_i != ACC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_q <= '0;
    end else if (load_bias_i) begin
      bias_q <= bias_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (last_i) begin
      res_q <= acc_d;
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/chan_conv_array.sv
module chan_conv_array
  import conv_array_pkg::*;
#(
  parameter int unsigned ROWS = DEF_ROWS,
  parameter int unsigned COLS = DEF_COLS,
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned ACCW = DEF_ACCW,
  parameter int unsigned KH   = DEF_KH,
  parameter int unsigned KW   = DEF_KW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [COLS*ACCW-1:0]     bias_i,
  input  logic                     valid_i,
  input  logic [ROWS*DW-1:0]       act_i,
  input  logic [ROWS*COLS*DW-1:0]  wgt_i,
  output logic                     done_o,
  output logic [COLS*ACCW-1:0]     result_o
);
  localparam int unsigned STEPS = KH * KW;
  localparam int unsigned STW   = (STEPS > 1) ? $clog2(STEPS) : 1;

  acc_op_e              acc_op;
  logic                 last_step;
  logic [STW-1:0]       step_cnt;
  logic [COLS*ACCW-1:0] col_sum;

  cw_step_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .op_o    (acc_op),
    .last_o  (last_step),
    .done_o  (done_o),
    .step_o  (step_cnt)
  );

  // One reduction tree per output-channel column; weights regrouped per column
  for (genvar c = 0; c < COLS; c++) begin : g_column
    logic [ROWS*DW-1:0] col_wgt;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign col_wgt[r*DW +: DW] = wgt_i[(r*COLS + c)*DW +: DW];
    end
    cw_col_tree #(.ROWS(ROWS), .DW(DW), .SW(ACCW)) u_tree (
      .act_i (act_i),
      .wgt_i (col_wgt),
      .sum_o (col_sum[c*ACCW +: ACCW])
    );
  end

  cw_acc_bank #(.COLS(COLS), .ACCW(ACCW)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_bias_i (start_i),
    .bias_i      (bias_i),
    .op_i        (acc_op),
    .last_i      (last_step),
    .col_sum_i   (col_sum),
    .result_o    (result_o)
  );

endmodule

// File: rtl/chan_conv_array_chk.sv
module chan_conv_array_chk #(
  parameter int unsigned OUTW  = 256,
  parameter int unsigned STEPS = 9,
  parameter int unsigned STW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            valid_i,
  input logic            done_o,
  input logic [OUTW-1:0] result_o,
  input logic [STW-1:0]  step_cnt
);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(valid_i) && !$past(start_i)));

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt < STW'(STEPS));

  // R4
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);

  // R5
  start_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (step_cnt == '0 && !done_o));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

endmodule

bind chan_conv_array chan_conv_array_chk #(
  .OUTW  (COLS*ACCW),
  .STEPS (KH*KW),
  .STW   ((KH*KW > 1) ? $clog2(KH*KW) : 1)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .valid_i  (valid_i),
  .done_o   (done_o),
  .result_o (result_o),
  .step_cnt (step_cnt)
);

// File: tb/tb_chan_conv_array.sv
module tb_chan_conv_array;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int DW   = 8;
  localparam int ACCW = 32;
  localparam int NPIX = 9;
  localparam int OUTW = COLS * ACCW;

  logic                    clk;
  logic                    rst_n;
  logic                    start_i;
  logic [OUTW-1:0]         bias_i;
  logic                    valid_i;
  logic [ROWS*DW-1:0]      act_i;
  logic [ROWS*COLS*DW-1:0] wgt_i;
  logic                    done_o;
  logic [OUTW-1:0]         result_o;

  chan_conv_array dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bias_i(bias_i),
    .valid_i(valid_i), .act_i(act_i), .wgt_i(wgt_i),
    .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  logic signed [DW-1:0]   act_m  [NPIX][ROWS];
  logic signed [DW-1:0]   wgt_m  [NPIX][ROWS][COLS];
  logic signed [ACCW-1:0] bias_m [COLS];

  logic [OUTW-1:0] exp_q [$];
  string           tag_q [$];
  logic            prev_done = 1'b0;

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      report();
    end
  end

  // Monitor: compare results as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && prev_done) begin
        checks++; fails++;
        $display("FAIL R2: done_o high two cycles (actual 1, expected 0)");
      end
      if (done_o && !prev_done) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: unexpected done_o (actual 1, expected 0)");
        end else begin
          logic [OUTW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          for (int c = 0; c < COLS; c++) begin
            checks++;
            if (result_o[c*ACCW +: ACCW] !== e[c*ACCW +: ACCW]) begin
              fails++;
              $display("FAIL %s col %0d: actual %0d expected %0d", t, c,
                       $signed(result_o[c*ACCW +: ACCW]), $signed(e[c*ACCW +: ACCW]));
            end
          end
        end
      end
    end
    prev_done = done_o;
  end

  task automatic fill(input int mode);
    for (int s = 0; s < NPIX; s++)
      for (int r = 0; r < ROWS; r++) begin
        case (mode)
          1: act_m[s][r] = -8'sd128;
          2: act_m[s][r] = 8'sd127;
          3: act_m[s][r] = 8'sd0;
          4: act_m[s][r] = 8'sd127;
          default: act_m[s][r] = DW'($urandom);
        endcase
        for (int c = 0; c < COLS; c++) begin
          case (mode)
            1, 2: wgt_m[s][r][c] = -8'sd128;
            3:    wgt_m[s][r][c] = 8'sd0;
            4:    wgt_m[s][r][c] = 8'sd127;
            default: wgt_m[s][r][c] = DW'($urandom);
          endcase
        end
      end
  endtask

  task automatic set_bias(input int mode);
    for (int c = 0; c < COLS; c++)
      case (mode)
        1: bias_m[c] = 32'sh7FFF_FFF0;
        2: bias_m[c] = ACCW'(c * 1000 - 3500);
        default: bias_m[c] = ACCW'($urandom);
      endcase
  endtask

  task automatic push_expected(input string tag);
    logic [OUTW-1:0] e;
    for (int c = 0; c < COLS; c++) begin
      logic signed [ACCW-1:0] acc;
      acc = bias_m[c];
      for (int s = 0; s < NPIX; s++)
        for (int r = 0; r < ROWS; r++)
          acc = acc + ACCW'(int'(act_m[s][r]) * int'(wgt_m[s][r][c]));
      e[c*ACCW +: ACCW] = acc;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic drive_junk(input logic v);
    valid_i = v;
    act_i   = {$urandom, $urandom};
    for (int k = 0; k < ROWS*COLS*DW/32; k++) wgt_i[k*32 +: 32] = $urandom;
  endtask

  task automatic drive_pixel(input int s);
    valid_i = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      act_i[r*DW +: DW] = act_m[s][r];
      for (int c = 0; c < COLS; c++) wgt_i[(r*COLS + c)*DW +: DW] = wgt_m[s][r][c];
    end
  endtask

  // start pulse; optionally with valid_i and junk data in the same cycle (R5)
  task automatic do_start(input logic with_valid);
    @(negedge clk);
    start_i = 1'b1;
    for (int c = 0; c < COLS; c++) bias_i[c*ACCW +: ACCW] = bias_m[c];
    drive_junk(with_valid);
    @(negedge clk);
    start_i = 1'b0;
    bias_i  = {8{$urandom}};
    valid_i = 1'b0;
  endtask

  // Drive pixels first..last-1; gaps inserts idle cycles with junk (R4)
  task automatic drive_range(input int first, input int last, input bit gaps);
    for (int s = first; s < last; s++) begin
      if (gaps && (s % 2 == 1)) begin
        drive_junk(1'b0);
        @(negedge clk);
        drive_junk(1'b0);
        @(negedge clk);
      end
      drive_pixel(s);
      @(negedge clk);
    end
    valid_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; valid_i = 1'b0;
    bias_i = '0; act_i = '0; wgt_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++; if (done_o !== 1'b0) begin fails++; $display("FAIL R1: done_o actual %b expected 0", done_o); end
    checks++; if (result_o !== '0) begin fails++; $display("FAIL R1: result_o actual %h expected 0", result_o); end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++; if (result_o !== '0 || done_o !== 1'b0) begin fails++; $display("FAIL R1: after release actual %b/%h expected 0/0", done_o, result_o); end

    // R3: random window
    set_bias(0); fill(0); do_start(1'b0); push_expected("R3 random");
    drive_range(0, NPIX, 0); repeat (3) @(negedge clk);

    // R4: idle gaps with junk data
    set_bias(2); fill(0); do_start(1'b0); push_expected("R4 gaps");
    drive_range(0, NPIX, 1); repeat (3) @(negedge clk);

    // R3: extreme values
    set_bias(2); fill(1); do_start(1'b0); push_expected("R3 min*min");
    drive_range(0, NPIX, 0);
    fill(2); do_start(1'b0); push_expected("R3 max*min");
    drive_range(0, NPIX, 0); repeat (3) @(negedge clk);

    // R5: restart mid-window, valid with start is ignored
    set_bias(0); fill(0); do_start(1'b0);
    drive_range(0, 5, 0);
    set_bias(2); fill(0); do_start(1'b1); push_expected("R5 restart");
    drive_range(0, NPIX, 0); repeat (3) @(negedge clk);

    // R6 + R8: back-to-back windows reuse bias; result holds mid-window
    set_bias(0); fill(0); do_start(1'b0); push_expected("R6 first");
    drive_range(0, NPIX, 0);
    fill(0); push_expected("R6 reuse bias");
    @(negedge clk);
    begin
      logic [OUTW-1:0] held;
      held = result_o;
      drive_range(0, 4, 0);
      @(negedge clk);
      checks++;
      if (result_o !== held) begin
        fails++; $display("FAIL R8: result_o actual %h expected %h", result_o, held);
      end
    end
    drive_range(4, NPIX, 1); repeat (3) @(negedge clk);

    // R7: wrap-around
    set_bias(1); fill(4); do_start(1'b0); push_expected("R7 wrap");
    drive_range(0, NPIX, 0); repeat (3) @(negedge clk);

    // R3: zero data gives bias
    set_bias(0); fill(3); do_start(1'b0); push_expected("R3 bias only");
    drive_range(0, NPIX, 0); repeat (4) @(negedge clk);

    // R2: every expected window completed exactly once
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R2: windows pending actual %0d expected 0", exp_q.size());
    end
    finished = 1;
    report();
  end

endmodule